// File: doc/BRIEF.md
# Wake-Event Status Synchronizer with Clear-on-Read

This block keeps two wake-event flags in the receive clock domain. One flag records a received wake-up frame and the other records a received magic packet. Each flag is set by a single-cycle event pulse on the receive clock. The flags remain set until a bus read clears them.

The bus side runs on a separate, faster clock. It sees the flags through per-bit two-flop synchronizers. These synchronized flags provide the status word on the read data port and an interrupt request, which is the OR of the flags.

A read strobe asks for both flags to be cleared. The request crosses to the receive domain as a toggle. An acknowledge toggle comes back, and no second clear is launched while one is still outstanding. The cleared value reaches the bus side several receive cycles later, so the interrupt can stay high for some time after a read. Software should therefore re-read the status until it shows zero. If an event arrives in the same receive cycle that a clear takes effect, the event wins.

Top module: `wk_status_sync`

## Requirements
- R1: After reset of both domains, rd_data reads all zero and irq is low.
- R2: A pulse on evt_wake sets status bit 0, and a pulse on evt_magic sets status bit 1. Each becomes visible on rd_data within a few receive cycles.
- R3: With no event and no clear, a flag keeps its value indefinitely.
- R4: irq is high exactly when some synchronized status bit is set. It is still high in the bus cycle after a read strobe that found a flag set.
- R5: A read strobe with no clear outstanding launches one clear. Afterwards both status bits read zero and irq falls.
- R6: A read strobe while a clear is outstanding launches nothing. Two back-to-back strobes still clear the flags exactly once.
- R7: An event pulse in the same receive cycle as an applied clear leaves that flag set.
- R8: rd_data bits above bit 1 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Active-low bus-domain reset |
| rx_clk | input | 1 | Receive clock |
| rx_rst_n | input | 1 | Active-low receive-domain reset |
| evt_wake | input | 1 | Wake-up frame event pulse, receive clock |
| evt_magic | input | 1 | Magic packet event pulse, receive clock |
| rd_stb | input | 1 | Status read strobe, bus clock, requests clear |
| rd_data | output | DATA_W | Status word: bit 0 wake, bit 1 magic |
| irq | output | 1 | Interrupt request, OR of synchronized flags |

## Verification
The assertions assume that both clocks run freely and that the event inputs change only in step with the receive clock. They also assume that rd_stb changes only in step with the bus clock, so both the event and strobe signals are single-domain. The bench meets these assumptions by driving events on receive-clock falling edges and strobes on bus-clock falling edges. It compares against settled values only after waiting several receive periods, because the crossing latency is not exact in bus cycles. The event-beats-clear case is covered by holding an event across the whole window in which the clear can land, so no exact cycle has to be known.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int unsigned EVT_N     = 2;
  localparam int unsigned BIT_WAKE  = 0;
  localparam int unsigned BIT_MAGIC = 1;

  typedef logic [EVT_N-1:0] evt_vec_t;

  // Next flag value: an applied clear empties, new events are OR-ed on top.
  function automatic evt_vec_t flag_next(evt_vec_t cur, logic clr, evt_vec_t ev);
    evt_vec_t base;
    base = clr ? '0 : cur;
    return base | ev;
  endfunction

  function automatic logic any_flag(evt_vec_t f);
    return |f;
  endfunction
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= stage[g-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/wk_rx_flags.sv
module wk_rx_flags
  import wk_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic     rx_clk,
  input  logic     rx_rst_n,
  input  evt_vec_t evt,
  input  logic     clr_tog_async,
  output evt_vec_t flags,
  output logic     ack_tog,
  output logic     clr_apply
);
  logic clr_tog_s;
  logic clr_seen;

  wk_sync #(.W(1), .STAGES(STAGES)) u_clr_sync (
    .clk  (rx_clk),
    .rst_n(rx_rst_n),
    .d    (clr_tog_async),
    .q    (clr_tog_s)
  );

  assign clr_apply = clr_tog_s ^ clr_seen;

  always_ff @(posedge rx_clk or negedge rx_rst_n) begin
    if (!rx_rst_n) begin
      clr_seen <= 1'b0;
      flags    <= '0;
    end else begin
      clr_seen <= clr_tog_s;
      flags    <= flag_next(flags, clr_apply, evt);
    end
  end

  assign ack_tog = clr_seen;
endmodule

// File: rtl/wk_bus_port.sv
module wk_bus_port
  import wk_pkg::*;
#(
  parameter int unsigned STAGES = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              rd_stb,
  input  evt_vec_t          flags_async,
  input  logic              ack_tog_async,
  output logic              req_tog,
  output logic              pending,
  output logic              launch,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int unsigned PAD_W = DATA_W - EVT_N;

  evt_vec_t flags_s;
  logic     ack_s;

  wk_sync #(.W(EVT_N), .STAGES(STAGES)) u_flag_sync (
    .clk  (bus_clk),
    .rst_n(bus_rst_n),
    .d    (flags_async),
    .q    (flags_s)
  );

  wk_sync #(.W(1), .STAGES(STAGES)) u_ack_sync (
    .clk  (bus_clk),
    .rst_n(bus_rst_n),
    .d    (ack_tog_async),
    .q    (ack_s)
  );

  assign pending = req_tog ^ ack_s;
  assign launch  = rd_stb & ~pending;

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n)  req_tog <= 1'b0;
    else if (launch) req_tog <= ~req_tog;
  end

  assign rd_data = {{PAD_W{1'b0}}, flags_s};
  assign irq     = any_flag(flags_s);
endmodule

// File: rtl/wk_status_sync.sv
module wk_status_sync
  import wk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_W      = 32
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              rx_clk,
  input  logic              rx_rst_n,
  input  logic              evt_wake,
  input  logic              evt_magic,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  evt_vec_t rx_evt;
  evt_vec_t rx_flags;
  logic     rx_ack_tog;
  logic     rx_clr_apply;
  logic     bus_req_tog;
  logic     bus_pending;
  logic     bus_launch;

  always_comb begin
    rx_evt            = '0;
    rx_evt[BIT_WAKE]  = evt_wake;
    rx_evt[BIT_MAGIC] = evt_magic;
  end

  wk_rx_flags #(.STAGES(SYNC_STAGES)) u_rx (
    .rx_clk       (rx_clk),
    .rx_rst_n     (rx_rst_n),
    .evt          (rx_evt),
    .clr_tog_async(bus_req_tog),
    .flags        (rx_flags),
    .ack_tog      (rx_ack_tog),
    .clr_apply    (rx_clr_apply)
  );

  wk_bus_port #(.STAGES(SYNC_STAGES), .DATA_W(DATA_W)) u_bus (
    .bus_clk      (bus_clk),
    .bus_rst_n    (bus_rst_n),
    .rd_stb       (rd_stb),
    .flags_async  (rx_flags),
    .ack_tog_async(rx_ack_tog),
    .req_tog      (bus_req_tog),
    .pending      (bus_pending),
    .launch       (bus_launch),
    .rd_data      (rd_data),
    .irq          (irq)
  );
endmodule

// File: rtl/wk_status_chk.sv
module wk_status_chk (
  input logic       rx_clk,
  input logic       rx_rst_n,
  input logic [1:0] evt,
  input logic [1:0] flags,
  input logic       clr_apply,
  input logic       bus_clk,
  input logic       bus_rst_n,
  input logic       rd_stb,
  input logic       pending,
  input logic       req_tog
);
  AST_EVT_SETS_FLAG: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    evt[0] |=> flags[0]); // R2
  AST_FLAGS_HOLD: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    (!clr_apply && evt == 2'b00) |=> $stable(flags)); // R3
  AST_CLEAR_EMPTIES: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    (clr_apply && !evt[1]) |=> !flags[1]); // R5
  AST_EVT_BEATS_CLEAR: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    (clr_apply && evt[1]) |=> flags[1]); // R7
  AST_READ_LAUNCHES: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (rd_stb && !pending) |=> (req_tog != $past(req_tog))); // R5
  AST_NO_SECOND_LAUNCH: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (rd_stb && pending) |=> $stable(req_tog)); // R6
endmodule

bind wk_status_sync wk_status_chk u_chk (
  .rx_clk   (rx_clk),
  .rx_rst_n (rx_rst_n),
  .evt      (rx_evt),
  .flags    (rx_flags),
  .clr_apply(rx_clr_apply),
  .bus_clk  (bus_clk),
  .bus_rst_n(bus_rst_n),
  .rd_stb   (rd_stb),
  .pending  (bus_pending),
  .req_tog  (bus_req_tog)
);

// File: tb/wk_status_sync_test.sv
module wk_status_sync_test;
  localparam int DW = 32;
  localparam time BUS_HALF = 10ns;
  localparam time RX_HALF  = 200ns;

  logic bus_clk = 0, rx_clk = 0;
  logic bus_rst_n = 0, rx_rst_n = 0;
  logic evt_wake = 0, evt_magic = 0, rd_stb = 0;
  logic [DW-1:0] rd_data;
  logic irq;

  int checks = 0, errors = 0;
  logic [1:0] model = 2'b00;

  always #BUS_HALF bus_clk = ~bus_clk;
  always #RX_HALF  rx_clk  = ~rx_clk;

  wk_status_sync uut (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .rx_clk(rx_clk), .rx_rst_n(rx_rst_n),
    .evt_wake(evt_wake), .evt_magic(evt_magic), .rd_stb(rd_stb),
    .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [DW-1:0] exp_word(logic [1:0] m);
    logic [DW-1:0] w;
    w = '0;
    w[0] = m[0];
    w[1] = m[1];
    return w;
  endfunction

  function automatic logic exp_irq(logic [1:0] m);
    return m != 2'b00;
  endfunction

  task automatic check_state(string req);
    checks++;
    if (rd_data !== exp_word(model) || irq !== exp_irq(model)) begin
      errors++;
      $display("FAIL %s rd_data=%h irq=%b expected rd_data=%h irq=%b",
               req, rd_data, irq, exp_word(model), exp_irq(model));
    end
  endtask

  task automatic settle();
    repeat (10) @(negedge rx_clk);
    @(negedge bus_clk);
  endtask

  task automatic pulse(logic w, logic m);
    @(negedge rx_clk);
    evt_wake = w; evt_magic = m;
    @(negedge rx_clk);
    evt_wake = 0; evt_magic = 0;
    model = model | {m, w};
  endtask

  task automatic read_once();
    @(negedge bus_clk);
    rd_stb = 1;
    @(negedge bus_clk);
    rd_stb = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge bus_clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge rx_clk);
    bus_rst_n = 1; rx_rst_n = 1;
    @(negedge bus_clk);
    check_state("R1 reset");
    checks++;
    if (rd_data[DW-1:2] !== '0) begin
      errors++; $display("FAIL R8 upper bits %h expected 0", rd_data[DW-1:2]);
    end

    // R2 wake only
    pulse(1, 0); settle(); check_state("R2 wake event");
    // R3 hold with nothing happening
    repeat (20) @(negedge rx_clk);
    @(negedge bus_clk); check_state("R3 hold");
    // R2 magic added
    pulse(0, 1); settle(); check_state("R2 magic event");

    // R4 irq still high right after read, R5 then clears
    @(negedge bus_clk);
    rd_stb = 1;
    @(negedge bus_clk);
    rd_stb = 0;
    checks++;
    if (irq !== 1'b1) begin errors++; $display("FAIL R4 irq after read=%b expected 1", irq); end
    model = 2'b00;
    settle(); check_state("R5 clear after read");

    // R6 back-to-back strobes clear exactly once
    pulse(1, 1); settle(); check_state("R2 both events");
    @(negedge bus_clk);
    rd_stb = 1;
    repeat (2) @(negedge bus_clk);
    rd_stb = 0;
    model = 2'b00;
    settle(); check_state("R6 double strobe clears once");

    // R7 event held across a clear window stays visible
    begin
      int bad = 0;
      @(negedge rx_clk);
      evt_magic = 1;
      repeat (4) @(negedge rx_clk);
      read_once();
      repeat (400) begin
        @(negedge bus_clk);
        if (rd_data[1] !== 1'b1) bad++;
      end
      @(negedge rx_clk);
      evt_magic = 0;
      model = 2'b10;
      checks++;
      if (bad != 0) begin
        errors++; $display("FAIL R7 magic bit dropped %0d cycles expected 0", bad);
      end
      settle(); check_state("R7 flag remains after clear");
      read_once(); model = 2'b00; settle(); check_state("R5 clear after R7");
    end

    // Random mix
    for (int i = 0; i < 30; i++) begin
      logic [1:0] ev;
      ev = 2'($urandom % 4);
      if (ev != 2'b00) pulse(ev[0], ev[1]);
      if ($urandom % 3 == 0) pulse(1'($urandom % 2), 1'($urandom % 2));
      settle(); check_state("R2 R4 random settle");
      checks++;
      if (rd_data[DW-1:2] !== '0) begin
        errors++; $display("FAIL R8 upper bits %h expected 0", rd_data[DW-1:2]);
      end
      if ($urandom % 2 == 0) begin
        read_once(); model = 2'b00;
        settle(); check_state("R5 random clear");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule